// File: doc/BRIEF.md
# Compressed Code-Size Instruction Expander

This block is a purely combinational expander for one group of 16-bit compressed instructions: short-offset byte and halfword loads and stores, a register multiply, a bitwise complement, and the byte, halfword and word sign/zero extensions. It turns each of them into the equivalent 32-bit base-ISA word, so a decode stage that understands only full-length instructions can run them unchanged.

The block has three mode inputs. `xlen64` selects 64-bit behaviour. `mulOn` states that the multiply extension is present. `bitOn` states that the bit-manipulation extension is present. Any pattern that falls outside the group is flagged illegal. So is a reserved slot inside the group, and so is an op whose prerequisite is missing. While the flag is high, the expanded word is all zeros, so the illegal path never passes a stale encoding downstream.

Top module: `cexp_expander`

## Requirements
- R1: Every 3-bit register field (bits 9:7 and bits 4:2) names register 8 plus the field value. The expanded 5-bit register number is {2'b01, field}.
- R2: Quadrant 00 with bits 15:10 = 100000 expands to an unsigned byte load. Its encoding is imm[11:0], rs1 = bits 9:7, funct3 100, rd = bits 4:2, opcode 0000011. Bits 15:10 = 100010 expands to a byte store: funct3 000, opcode 0100011, rs2 = bits 4:2, rs1 = bits 9:7. In both cases the zero-extended offset has bit 1 = instruction bit 5 and bit 0 = instruction bit 6.
- R3: Quadrant 00 with bits 15:10 = 100001 is a halfword load, with opcode 0000011. Bit 6 = 1 gives funct3 001 (sign-extending) and bit 6 = 0 gives funct3 101 (zero-extending). Bits 15:10 = 100011 with bit 6 = 0 is a halfword store, with funct3 001 and opcode 0100011. For all halfword forms, offset bit 1 = instruction bit 5 and offset bit 0 = 0.
- R4: Quadrant 01 with bits 15:10 = 100111 and bits 6:5 = 10 expands to a multiply. The encoding is funct7 0000001, rs2 = bits 4:2, rs1 = rd = bits 9:7, funct3 000, opcode 0110011. The expansion happens only when `mulOn` = 1; otherwise the pattern is illegal.
- R5: The unary group (quadrant 01, bits 15:10 = 100111, bits 6:5 = 11) with bits 4:2 = 101 expands to an XOR-immediate with 0xFFF: funct3 100, opcode 0010011, rs1 = rd = bits 9:7. This op is legal regardless of the enables.
- R6: In the unary group, the following selects expand to I-type words with opcode 0010011 and rs1 = rd = bits 9:7. Select 000 gives an AND-immediate with 0x0FF and funct3 111. Select 001 gives immediate 0x604 with funct3 001, which is the byte sign-extend. Select 011 gives immediate 0x605 with funct3 001, which is the halfword sign-extend. All three are illegal when `bitOn` = 0.
- R7: Unary select 010 (halfword zero-extend) expands to funct7 0000100, rs2 0, funct3 100, rd = rs1 = bits 9:7. Its opcode is 0110011 when `xlen64` = 0 and 0111011 when `xlen64` = 1. It is illegal when `bitOn` = 0.
- R8: Unary select 100 (word zero-extend) expands to an add-unsigned-word with x0: funct7 0000100, rs2 0, funct3 000, opcode 0111011. It is legal only when both `xlen64` = 1 and `bitOn` = 1.
- R9: Unary selects 110 and 111 are reserved and raise the illegal flag. So does the halfword-store pattern with bit 6 = 1.
- R10: Every pattern outside the group is illegal. This covers other quadrants, other values of bits 15:10, and bits 6:5 = 00 or 01 under 100111. Whenever `illegal` is 1, `instrOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrIn | input | 16 | Compressed instruction word |
| xlen64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| mulOn | input | 1 | Multiply extension present |
| bitOn | input | 1 | Bit-manipulation extension present |
| instrOut | output | 32 | Expanded 32-bit instruction, zero when illegal |
| illegal | output | 1 | Pattern reserved, outside the group, or prerequisite absent |

## Verification
The block holds no state, so a wrong internal decision appears on `instrOut` or `illegal` in the same cycle the pattern is applied. A misrouted strobe shows as the wrong opcode or funct field. A bad register mapping shows as a wrong register number in the 5-bit field. A gating fault shows as the illegal flag disagreeing with the enable combination. The bench applies every pattern of the group's five bits-15:10 values in three quadrants under all eight enable combinations, then sweeps all 64 values of bits 15:10 with sample low bits. That way each such fault lands on a specific pattern.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int CW = 16;
  localparam int XW = 32;
  localparam int RW = 5;
  localparam int IMMW = 12;

  localparam logic [6:0] OP_LOAD = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_IMM = 7'b0010011;
  localparam logic [6:0] OP_REG = 7'b0110011;
  localparam logic [6:0] OP_REG32 = 7'b0111011;

  localparam logic [5:0] F6_LBU = 6'b100000;
  localparam logic [5:0] F6_LHX = 6'b100001;
  localparam logic [5:0] F6_SB = 6'b100010;
  localparam logic [5:0] F6_SH = 6'b100011;
  localparam logic [5:0] F6_ARITH = 6'b100111;

  localparam logic [IMMW-1:0] IMM_SEXTB = 12'h604;
  localparam logic [IMMW-1:0] IMM_SEXTH = 12'h605;
  localparam logic [IMMW-1:0] IMM_BYTEMASK = 12'h0FF;
  localparam logic [IMMW-1:0] IMM_ALLONES = 12'hFFF;

  typedef struct packed {
    logic ldByte;
    logic ldHalf;
    logic ldSigned;
    logic stByte;
    logic stHalf;
    logic mul;
    logic opNot;
    logic zextB;
    logic sextB;
    logic zextH;
    logic sextH;
    logic zextW;
    logic illegal;
  } strobe_t;
endpackage

// File: rtl/cexp_ctrl.sv
module cexp_ctrl
  import cexp_pkg::*;
(
  input  logic [CW-1:0] instrIn,
  input  logic          xlen64,
  input  logic          mulOn,
  input  logic          bitOn,
  output strobe_t       strb
);
  logic [1:0] quad;
  logic [5:0] funct6;
  logic [2:0] unarySel;
  logic [1:0] arithSel;
  logic       anyOp;

  assign quad = instrIn[1:0];
  assign funct6 = instrIn[15:10];
  assign unarySel = instrIn[4:2];
  assign arithSel = instrIn[6:5];

  always_comb begin
    strb = '0;
    if (quad == 2'b00) begin
      unique case (funct6)
        F6_LBU: strb.ldByte = 1'b1;
        F6_LHX: begin
          strb.ldHalf = 1'b1;
          strb.ldSigned = instrIn[6];
        end
        F6_SB: strb.stByte = 1'b1;
        F6_SH: strb.stHalf = ~instrIn[6];
        default: ;
      endcase
    end else if (quad == 2'b01 && funct6 == F6_ARITH) begin
      if (arithSel == 2'b10) begin
        strb.mul = mulOn;
      end else if (arithSel == 2'b11) begin
        unique case (unarySel)
          3'b000: strb.zextB = bitOn;
          3'b001: strb.sextB = bitOn;
          3'b010: strb.zextH = bitOn;
          3'b011: strb.sextH = bitOn;
          3'b100: strb.zextW = bitOn & xlen64;
          3'b101: strb.opNot = 1'b1;
          default: ;
        endcase
      end
    end
    anyOp = strb.ldByte | strb.ldHalf | strb.stByte | strb.stHalf | strb.mul |
            strb.opNot | strb.zextB | strb.sextB | strb.zextH | strb.sextH | strb.zextW;
    strb.illegal = ~anyOp;

    AST_MUL_NEEDS_ENABLE: assert (!strb.mul || mulOn); // R4
    AST_WORDZ_NEEDS_64: assert (!strb.zextW || (xlen64 && bitOn)); // R8
    AST_EXT_NEEDS_BIT: assert (!(strb.zextB | strb.sextB | strb.zextH | strb.sextH) || bitOn); // R6
    AST_RESERVED_SEL: assert (!(quad == 2'b01 && funct6 == F6_ARITH && arithSel == 2'b11 && unarySel[2:1] == 2'b11) || strb.illegal); // R9
    AST_ONE_STROBE: assert ($onehot({strb.ldByte, strb.ldHalf, strb.stByte, strb.stHalf, strb.mul, strb.opNot, strb.zextB, strb.sextB, strb.zextH, strb.sextH, strb.zextW, strb.illegal})); // R10
  end
endmodule

// File: rtl/cexp_datapath.sv
module cexp_datapath
  import cexp_pkg::*;
(
  input  logic [CW-1:0] instrIn,
  input  logic          xlen64,
  input  strobe_t       strb,
  output logic [XW-1:0] instrOut
);
  logic [RW-1:0]   regHi;
  logic [RW-1:0]   regLo;
  logic [IMMW-1:0] offByte;
  logic [IMMW-1:0] offHalf;
  logic [IMMW-1:0] stOff;
  logic [6:0]      zextHOp;

  // R1: compressed register fields reach registers 8..15
  assign regHi = {2'b01, instrIn[9:7]};
  assign regLo = {2'b01, instrIn[4:2]};
  assign offByte = {{(IMMW-2){1'b0}}, instrIn[5], instrIn[6]};
  assign offHalf = {{(IMMW-2){1'b0}}, instrIn[5], 1'b0};
  assign stOff = strb.stHalf ? offHalf : offByte;
  assign zextHOp = xlen64 ? OP_REG32 : OP_REG;

  always_comb begin
    instrOut = '0;
    if (strb.ldByte)
      instrOut = {offByte, regHi, 3'b100, regLo, OP_LOAD};
    else if (strb.ldHalf)
      instrOut = {offHalf, regHi, (strb.ldSigned ? 3'b001 : 3'b101), regLo, OP_LOAD};
    else if (strb.stByte || strb.stHalf)
      instrOut = {stOff[11:5], regLo, regHi, (strb.stHalf ? 3'b001 : 3'b000), stOff[4:0], OP_STORE};
    else if (strb.mul)
      instrOut = {7'b0000001, regLo, regHi, 3'b000, regHi, OP_REG};
    else if (strb.opNot)
      instrOut = {IMM_ALLONES, regHi, 3'b100, regHi, OP_IMM};
    else if (strb.zextB)
      instrOut = {IMM_BYTEMASK, regHi, 3'b111, regHi, OP_IMM};
    else if (strb.sextB)
      instrOut = {IMM_SEXTB, regHi, 3'b001, regHi, OP_IMM};
    else if (strb.sextH)
      instrOut = {IMM_SEXTH, regHi, 3'b001, regHi, OP_IMM};
    else if (strb.zextH)
      instrOut = {7'b0000100, 5'd0, regHi, 3'b100, regHi, zextHOp};
    else if (strb.zextW)
      instrOut = {7'b0000100, 5'd0, regHi, 3'b000, regHi, OP_REG32};

    AST_LEGAL_FULL_WIDTH: assert (strb.illegal || instrOut[1:0] == 2'b11); // R10
  end
endmodule

// File: rtl/cexp_expander.sv
module cexp_expander
  import cexp_pkg::*;
(
  input  logic [15:0] instrIn,
  input  logic        xlen64,
  input  logic        mulOn,
  input  logic        bitOn,
  output logic [31:0] instrOut,
  output logic        illegal
);
  strobe_t strb;

  cexp_ctrl u_ctrl (
    .instrIn (instrIn),
    .xlen64  (xlen64),
    .mulOn   (mulOn),
    .bitOn   (bitOn),
    .strb    (strb)
  );

  cexp_datapath u_dp (
    .instrIn  (instrIn),
    .xlen64   (xlen64),
    .strb     (strb),
    .instrOut (instrOut)
  );

  assign illegal = strb.illegal;
endmodule

// File: tb/test_cexp_expander.sv
module test_cexp_expander;
  logic        clk = 1'b0;
  logic [15:0] instrIn = '0;
  logic        xlen64 = 1'b0;
  logic        mulOn = 1'b0;
  logic        bitOn = 1'b0;
  logic [31:0] instrOut;
  logic        illegal;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cexp_expander i_cexp_expander (
    .instrIn  (instrIn),
    .xlen64   (xlen64),
    .mulOn    (mulOn),
    .bitOn    (bitOn),
    .instrOut (instrOut),
    .illegal  (illegal)
  );

  function automatic int encI(int imm, int rs1, int f3, int rd, int op);
    return (imm << 20) + (rs1 << 15) + (f3 << 12) + (rd << 7) + op;
  endfunction

  function automatic int encS(int imm, int rs2, int rs1, int f3, int op);
    return ((imm / 32) << 25) + (rs2 << 20) + (rs1 << 15) + (f3 << 12) + ((imm % 32) << 7) + op;
  endfunction

  function automatic int encR(int f7, int rs2, int rs1, int f3, int rd, int op);
    return (f7 << 25) + (rs2 << 20) + (rs1 << 15) + (f3 << 12) + (rd << 7) + op;
  endfunction

  // reference: returns expected word, sets ill and a requirement tag
  function automatic int refExpand(input logic [15:0] c, input bit x64, input bit mEn,
                                   input bit bEn, output bit ill, output string tag);
    int a = 8 + int'(c[9:7]);
    int b = 8 + int'(c[4:2]);
    int offB = 2 * int'(c[5]) + int'(c[6]);
    int offH = 2 * int'(c[5]);
    int f6 = int'(c[15:10]);
    ill = 1'b0;
    tag = "R10";
    if (c[1:0] == 2'b00) begin
      if (f6 == 32) begin tag = "R2 R1"; return encI(offB, a, 4, b, 3); end
      if (f6 == 33) begin tag = "R3 R1"; return encI(offH, a, c[6] ? 1 : 5, b, 3); end
      if (f6 == 34) begin tag = "R2 R1"; return encS(offB, b, a, 0, 35); end
      if (f6 == 35) begin
        if (c[6]) begin tag = "R9"; ill = 1'b1; return 0; end
        tag = "R3 R1"; return encS(offH, b, a, 1, 35);
      end
      ill = 1'b1; return 0;
    end
    if (c[1:0] == 2'b01 && f6 == 39) begin
      if (c[6:5] == 2'b10) begin
        tag = "R4";
        if (!mEn) begin ill = 1'b1; return 0; end
        return encR(1, b, a, 0, a, 51);
      end
      if (c[6:5] == 2'b11) begin
        case (int'(c[4:2]))
          0: begin tag = "R6"; if (bEn) return encI(255, a, 7, a, 19); end
          1: begin tag = "R6"; if (bEn) return encI(1540, a, 1, a, 19); end
          2: begin tag = "R7"; if (bEn) return encR(4, 0, a, 4, a, x64 ? 59 : 51); end
          3: begin tag = "R6"; if (bEn) return encI(1541, a, 1, a, 19); end
          4: begin tag = "R8"; if (bEn && x64) return encR(4, 0, a, 0, a, 59); end
          5: begin tag = "R5"; return encI(4095, a, 4, a, 19); end
          default: tag = "R9";
        endcase
        ill = 1'b1; return 0;
      end
    end
    ill = 1'b1;
    return 0;
  endfunction

  task automatic applyCheck(input logic [15:0] c, input bit x64, input bit mEn, input bit bEn);
    bit    expIll;
    string tag;
    int    expWord;
    instrIn = c; xlen64 = x64; mulOn = mEn; bitOn = bEn;
    expWord = refExpand(c, x64, mEn, bEn, expIll, tag);
    @(negedge clk);
    checks++;
    if (instrOut !== expWord[31:0] || illegal !== expIll) begin
      errors++;
      $display("FAIL %s in=%h x64=%0b mul=%0b bit=%0b got=%h/%0b exp=%h/%0b",
               tag, c, x64, mEn, bEn, instrOut, illegal, expWord[31:0], expIll);
    end
    @(posedge clk);
  endtask

  initial begin
    logic [5:0] groupF6 [5] = '{6'b100000, 6'b100001, 6'b100010, 6'b100011, 6'b100111};
    logic [7:0] lows [4] = '{8'h00, 8'h55, 8'hAA, 8'hFF};
    @(posedge clk);
    // idle input: all-zero word is outside the group (R10)
    applyCheck(16'h0000, 1'b0, 1'b0, 1'b0);
    // exhaustive in-group sweep under every enable combination (R1..R9)
    for (int e = 0; e < 8; e++)
      for (int g = 0; g < 5; g++)
        for (int q = 0; q < 3; q++)
          for (int low = 0; low < 256; low++)
            applyCheck({groupF6[g], low[7:0], q[1:0]}, e[2], e[1], e[0]);
    // every funct6 and quadrant with sample low bits (R10)
    for (int e = 0; e < 8; e++)
      for (int f = 0; f < 64; f++)
        for (int q = 0; q < 4; q++)
          for (int k = 0; k < 4; k++)
            applyCheck({f[5:0], lows[k], q[1:0]}, e[2], e[1], e[0]);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule